// File: doc/BRIEF.md
# Shifted-Operand Add with Flags

This block takes one 32-bit instruction word per cycle that asks for the sum of a register and a second register passed through a barrel shifter. It decodes the word, takes the two operand values that an external register-read port delivers in the same cycle, shifts the second operand left, logically right or arithmetically right, adds, and derives the negative, zero, carry and overflow flags. The operation runs at 32 or 64 bits, as the word selects.

Every result is registered. It appears exactly one clock after the valid strobe, whatever the operand values. Besides the sum and flags, the block reports the three register indices, whether each source names the hard-wired zero register, whether the destination register should be written, whether the flags should be written, and whether the word is an undefined encoding. The block only reports an undefined encoding. Raising an exception is left to the surrounding pipeline.

Top module: `shadd_unit`

## Requirements
- R1: A word is recognised only when bits 30:24 equal 0101011 and bit 21 is 0. Any other word raises `undef_op`, and `wr_en` and `flags_en` stay low.
- R2: Bit 31 selects the width: 0 gives 32 bits and 1 gives 64 bits. At 32 bits only bits 31:0 of each operand are used, and `result[63:32]` is zero.
- R3: Bits 23:22 select the shift applied to the second operand: 00 is logical left, 01 is logical right and 10 is arithmetic right, which copies the top bit of the active width. The shift amount is bits 15:10 read as an unsigned number.
- R4: Shift code 11 raises `undef_op`.
- R5: At 32 bits, a set bit 15 (the top bit of the amount) raises `undef_op`. At 64 bits, amounts from 0 to 63 are all accepted.
- R6: `result` equals the first operand plus the shifted second operand, modulo 2 to the power of the active width.
- R7: The flags are taken at the active width. N is the top bit of the sum. Z is set when the sum is zero. C is the carry out of the top bit. V is set when the two addends have the same sign and the sum has a different sign.
- R8: For a recognised, defined word, `flags_en` is 1. `wr_en` is 1 unless the destination index (bits 4:0) is 31, in which case only the flags are updated.
- R9: When `undef_op` is 1, both `wr_en` and `flags_en` are 0.
- R10: `rd_idx`, `rn_idx` and `rm_idx` carry bits 4:0, 9:5 and 20:16. A source index of 31 sets `rn_zero` or `rm_zero`, and that operand is used as zero whatever value is on the operand input.
- R11: `out_valid` is 1 exactly one cycle after `in_valid`. While `out_valid` is 0, `wr_en` and `flags_en` are 0.
- R12: A synchronous active-high reset clears `out_valid`, `wr_en` and `flags_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands present |
| instr | input | 32 | Instruction word |
| opnd_a | input | 64 | Value of the first source register |
| opnd_b | input | 64 | Value of the second source register |
| out_valid | output | 1 | Registered outputs hold a result |
| rd_idx | output | 5 | Destination register index |
| rn_idx | output | 5 | First source index |
| rm_idx | output | 5 | Second source index |
| rn_zero | output | 1 | First source is the zero register |
| rm_zero | output | 1 | Second source is the zero register |
| result | output | 64 | Sum, zero-extended at 32 bits |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| wr_en | output | 1 | Write `result` to `rd_idx` |
| flags_en | output | 1 | Write the four flags |
| undef_op | output | 1 | Undefined or unrecognised encoding |

## Verification
The bench targets shift amounts of 0 and of the width minus one. A shifter that wraps or drops its top amount bit would return the unshifted operand or a wrong bit. Arithmetic right shifts at 32 bits check that the sign comes from bit 31 and not bit 63, and that upper-half operand garbage cannot leak into the sum or the carry. Every reserved form is exercised: shift code 11, the 32-bit amount with bit 5 set, and words with a wrong fixed bit. A design that missed any of these would assert a write enable. Compares with destination 31, and sources 31 with garbage on the operand bus, show whether the destination register is wrongly written or whether the raw operand value wrongly enters the sum.

// File: rtl/shadd_pkg.sv
package shadd_pkg;

    localparam int XLEN      = 64;
    localparam int HALF      = XLEN / 2;
    localparam int IDX_W     = 5;
    localparam int AMT_W     = 6;
    localparam logic [IDX_W-1:0] ZERO_REG = '1;
    localparam logic [6:0]       OPC_HI   = 7'b0101011;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_RSV = 2'b11
    } shift_e;

    typedef struct packed {
        logic             wide;
        shift_e           kind;
        logic [AMT_W-1:0] amt;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rm;
        logic             match;
        logic             undef;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic fixed_bits_ok(input logic [31:0] w);
        return (w[30:24] == OPC_HI) && (w[21] == 1'b0);
    endfunction

endpackage

// File: rtl/shadd_decode.sv
module shadd_decode
    import shadd_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic rsv_shift;
    logic narrow_amt_bad;

    always_comb begin
        dec.wide  = instr[31];
        dec.kind  = shift_e'(instr[23:22]);
        dec.amt   = instr[15:10];
        dec.rm    = instr[20:16];
        dec.rn    = instr[9:5];
        dec.rd    = instr[4:0];
        dec.match = fixed_bits_ok(instr);
        rsv_shift      = (dec.kind == SH_RSV);
        narrow_amt_bad = !dec.wide && dec.amt[AMT_W-1];
        dec.undef = !dec.match || rsv_shift || narrow_amt_bad;
    end
endmodule

// File: rtl/shadd_shift.sv
module shadd_shift
    import shadd_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]         val,
    input  shift_e               kind,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         out
);
    always_comb begin
        unique case (kind)
            SH_LSL:  out = val << amt;
            SH_LSR:  out = val >> amt;
            SH_ASR:  out = W'($signed(val) >>> amt);
            default: out = val;
        endcase
    end
endmodule

// File: rtl/shadd_addf.sv
module shadd_addf
    import shadd_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output flags_t       fl
);
    logic [W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b};
        sum      = wide_sum[W-1:0];
        fl.n     = wide_sum[W-1];
        fl.z     = (wide_sum[W-1:0] == '0);
        fl.c     = wide_sum[W];
        fl.v     = (a[W-1] == b[W-1]) && (wide_sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/shadd_unit.sv
module shadd_unit
    import shadd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    output logic             out_valid,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] rn_idx,
    output logic [IDX_W-1:0] rm_idx,
    output logic             rn_zero,
    output logic             rm_zero,
    output logic [XLEN-1:0]  result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v,
    output logic             wr_en,
    output logic             flags_en,
    output logic             undef_op
);
    localparam int NLANE = 2;

    dec_t            dec;
    logic            a_is_zr, b_is_zr;
    logic [XLEN-1:0] op_a, op_b;
    logic [XLEN-1:0] lane_sum [NLANE];
    flags_t          lane_fl  [NLANE];
    logic [XLEN-1:0] sel_sum;
    flags_t          sel_fl;
    flags_t          fl_q;
    logic            wide_q;

    shadd_decode u_dec (.instr(instr), .dec(dec));

    assign a_is_zr = (dec.rn == ZERO_REG);
    assign b_is_zr = (dec.rm == ZERO_REG);
    assign op_a    = a_is_zr ? '0 : opnd_a;
    assign op_b    = b_is_zr ? '0 : opnd_b;

    // lane 0 is the narrow datapath, lane 1 the full width one
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int W = (g == 0) ? HALF : XLEN;
        logic [W-1:0] a_l, b_l, sh_l, s_l;
        flags_t       f_l;

        assign a_l = op_a[W-1:0];
        assign b_l = op_b[W-1:0];

        shadd_shift #(.W(W)) u_sh (
            .val  (b_l),
            .kind (dec.kind),
            .amt  (dec.amt[$clog2(W)-1:0]),
            .out  (sh_l)
        );

        shadd_addf #(.W(W)) u_add (
            .a   (a_l),
            .b   (sh_l),
            .sum (s_l),
            .fl  (f_l)
        );

        assign lane_sum[g] = XLEN'(s_l);
        assign lane_fl[g]  = f_l;
    end

    assign sel_sum = dec.wide ? lane_sum[1] : lane_sum[0];
    assign sel_fl  = dec.wide ? lane_fl[1]  : lane_fl[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            flags_en  <= 1'b0;
            undef_op  <= 1'b0;
            wide_q    <= 1'b0;
            rd_idx    <= '0;
            rn_idx    <= '0;
            rm_idx    <= '0;
            rn_zero   <= 1'b0;
            rm_zero   <= 1'b0;
            result    <= '0;
            fl_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                undef_op <= dec.undef;
                flags_en <= !dec.undef;
                wr_en    <= !dec.undef && (dec.rd != ZERO_REG);
                wide_q   <= dec.wide;
                rd_idx   <= dec.rd;
                rn_idx   <= dec.rn;
                rm_idx   <= dec.rm;
                rn_zero  <= a_is_zr;
                rm_zero  <= b_is_zr;
                result   <= sel_sum;
                fl_q     <= sel_fl;
            end else begin
                undef_op <= 1'b0;
                flags_en <= 1'b0;
                wr_en    <= 1'b0;
            end
        end
    end

    assign flag_n = fl_q.n;
    assign flag_z = fl_q.z;
    assign flag_c = fl_q.c;
    assign flag_v = fl_q.v;

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wr_en && !flags_en));

    p_undef_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && undef_op) |-> (!wr_en && !flags_en));

    p_cmp_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rd_idx == ZERO_REG) |-> !wr_en);

    p_narrow_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !undef_op && !wide_q) |-> (result[XLEN-1:HALF] == '0));

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !undef_op) |->
        (flag_z == (wide_q ? (result == '0) : (result[HALF-1:0] == '0))));

endmodule

// File: tb/tb_shadd_unit.sv
`timescale 1ns/1ps
module tb_shadd_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] opnd_a, opnd_b;
    logic        out_valid, rn_zero, rm_zero;
    logic [4:0]  rd_idx, rn_idx, rm_idx;
    logic [63:0] result;
    logic        flag_n, flag_z, flag_c, flag_v, wr_en, flags_en, undef_op;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    shadd_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx),
        .rn_zero(rn_zero), .rm_zero(rm_zero), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .wr_en(wr_en), .flags_en(flags_en), .undef_op(undef_op)
    );

    function automatic logic [31:0] enc(input logic sf, input logic [1:0] sh,
                                        input logic [4:0] rm, input logic [5:0] amt,
                                        input logic [4:0] rn, input logic [4:0] rd);
        return {sf, 7'b0101011, sh, 1'b0, rm, amt, rn, rd};
    endfunction

    // stimulus and expected values for a few hand-worked cases
    localparam int NT = 7;
    localparam logic [NT-1:0][31:0] T_INS = '{
        enc(1'b1, 2'b10, 5'd3, 6'd63, 5'd2, 5'd1),
        enc(1'b0, 2'b01, 5'd3, 6'd31, 5'd2, 5'd1),
        enc(1'b0, 2'b00, 5'd3, 6'd0,  5'd2, 5'd1),
        enc(1'b0, 2'b10, 5'd3, 6'd31, 5'd2, 5'd1),
        enc(1'b1, 2'b01, 5'd3, 6'd4,  5'd2, 5'd1),
        enc(1'b1, 2'b00, 5'd3, 6'd63, 5'd2, 5'd1),
        enc(1'b1, 2'b00, 5'd3, 6'd0,  5'd2, 5'd1)
    };
    localparam logic [NT-1:0][63:0] T_A = '{
        64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF, 64'd0,
        64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1
    };
    localparam logic [NT-1:0][63:0] T_B = '{
        64'h8000_0000_0000_0000, 64'hFFFF_FFFF_8000_0000, 64'd1,
        64'h0000_0000_8000_0000, 64'h10, 64'd1, 64'd2
    };
    localparam logic [NT-1:0][63:0] T_RES = '{
        64'd4, 64'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF,
        64'd0, 64'h8000_0000_0000_0000, 64'd3
    };
    localparam logic [NT-1:0][3:0] T_NZCV = '{
        4'b0010, 4'b0110, 4'b1001, 4'b1000, 4'b0110, 4'b1000, 4'b0000
    };

    function automatic void model(input logic [31:0] w, input logic [63:0] a, b,
                                  output logic und, output logic [63:0] res,
                                  output logic [3:0] nzcv, output logic we, fe);
        logic        sf;
        logic [1:0]  sh;
        logic [5:0]  amt;
        logic [63:0] aa, bb, bs;
        logic [64:0] s65;
        logic [31:0] bs32;
        logic [32:0] s33;
        sf  = w[31];
        sh  = w[23:22];
        amt = w[15:10];
        und = (w[30:24] != 7'b0101011) || w[21] || (sh == 2'b11) || (!sf && amt[5]);
        aa  = (w[9:5]   == 5'd31) ? 64'd0 : a;
        bb  = (w[20:16] == 5'd31) ? 64'd0 : b;
        if (sf) begin
            case (sh)
                2'b00:   bs = bb << amt;
                2'b01:   bs = bb >> amt;
                default: bs = $signed(bb) >>> amt;
            endcase
            s65  = {1'b0, aa} + {1'b0, bs};
            res  = s65[63:0];
            nzcv = {res[63], res == 64'd0, s65[64],
                    (aa[63] == bs[63]) && (res[63] != aa[63])};
        end else begin
            case (sh)
                2'b00:   bs32 = bb[31:0] << amt[4:0];
                2'b01:   bs32 = bb[31:0] >> amt[4:0];
                default: bs32 = $signed(bb[31:0]) >>> amt[4:0];
            endcase
            s33  = {1'b0, aa[31:0]} + {1'b0, bs32};
            res  = {32'd0, s33[31:0]};
            nzcv = {s33[31], s33[31:0] == 32'd0, s33[32],
                    (aa[31] == bs32[31]) && (s33[31] != aa[31])};
        end
        fe = !und;
        we = !und && (w[4:0] != 5'd31);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [63:0] a, b);
        @(negedge clk);
        instr    = w;
        opnd_a   = a;
        opnd_b   = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic verify(input string req, input logic [31:0] w, input logic [63:0] a, b);
        logic        und, we, fe;
        logic [63:0] res;
        logic [3:0]  nzcv;
        apply(w, a, b);
        model(w, a, b, und, res, nzcv, we, fe);
        check("R11", "out_valid", 64'(out_valid), 64'd1);
        check(req, "undef_op", 64'(undef_op), 64'(und));
        check(req, "wr_en", 64'(wr_en), 64'(we));
        check(req, "flags_en", 64'(flags_en), 64'(fe));
        check("R10", "indices", {49'd0, rd_idx, rn_idx, rm_idx},
              {49'd0, w[4:0], w[9:5], w[20:16]});
        check("R10", "zero flags", {62'd0, rn_zero, rm_zero},
              {62'd0, w[9:5] == 5'd31, w[20:16] == 5'd31});
        if (!und) begin
            check(req, "result", result, res);
            check(req, "nzcv", {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, nzcv});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "out_valid in reset", 64'(out_valid), 64'd0);
        check("R12", "enables in reset", {62'd0, wr_en, flags_en}, 64'd0);
        rst = 1'b0;

        // table of hand-computed vectors: R3 R6 R7, shift 0 and maximum
        for (int i = 0; i < NT; i++) begin
            apply(T_INS[i], T_A[i], T_B[i]);
            check("R6", "table result", result, T_RES[i]);
            check("R7", "table nzcv", {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, T_NZCV[i]});
            check("R8", "table enables", {62'd0, wr_en, flags_en}, 64'd3);
        end

        // R11: no strobe, no valid
        @(negedge clk);
        check("R11", "idle out_valid", 64'(out_valid), 64'd0);
        check("R11", "idle enables", {62'd0, wr_en, flags_en}, 64'd0);

        // R4: reserved shift code at both widths
        verify("R4", enc(1'b1, 2'b11, 5'd3, 6'd1, 5'd2, 5'd1), 64'd7, 64'd9);
        check("R4", "undef 64", 64'(undef_op), 64'd1);
        verify("R4", enc(1'b0, 2'b11, 5'd3, 6'd0, 5'd2, 5'd1), 64'd7, 64'd9);
        check("R9", "enables low", {62'd0, wr_en, flags_en}, 64'd0);

        // R5: narrow amount with top bit set; wide amount 63 accepted
        verify("R5", enc(1'b0, 2'b00, 5'd3, 6'd32, 5'd2, 5'd1), 64'd1, 64'd1);
        check("R5", "narrow amt undef", 64'(undef_op), 64'd1);
        verify("R5", enc(1'b1, 2'b01, 5'd3, 6'd63, 5'd2, 5'd1), 64'd1, 64'h8000_0000_0000_0000);
        check("R5", "wide amt 63 defined", 64'(undef_op), 64'd0);

        // R1: wrong fixed bits
        verify("R1", enc(1'b1, 2'b00, 5'd3, 6'd0, 5'd2, 5'd1) | 32'h4000_0000, 64'd1, 64'd1);
        check("R1", "bit30 undef", 64'(undef_op), 64'd1);
        verify("R1", enc(1'b0, 2'b00, 5'd3, 6'd0, 5'd2, 5'd1) | 32'h0020_0000, 64'd1, 64'd1);
        check("R1", "bit21 undef", 64'(undef_op), 64'd1);
        verify("R1", enc(1'b1, 2'b00, 5'd3, 6'd0, 5'd2, 5'd1) ^ 32'h0100_0000, 64'd1, 64'd1);
        check("R9", "mismatch enables", {62'd0, wr_en, flags_en}, 64'd0);

        // R8: destination 31 updates flags only
        verify("R8", enc(1'b1, 2'b00, 5'd3, 6'd0, 5'd2, 5'd31), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        check("R8", "compare enables", {62'd0, wr_en, flags_en}, 64'd1);
        check("R7", "compare zero+carry", {60'd0, flag_n, flag_z, flag_c, flag_v}, 64'b0110);

        // R10: zero register sources ignore operand bus
        verify("R10", enc(1'b1, 2'b00, 5'd3, 6'd2, 5'd31, 5'd1), 64'hDEAD_BEEF_0000_1234, 64'd5);
        check("R10", "rn zero result", result, 64'd20);
        verify("R10", enc(1'b0, 2'b00, 5'd31, 6'd0, 5'd4, 5'd1), 64'hFFFF_FFFF_0000_0009, 64'h1234);
        check("R10", "rm zero result", result, 64'd9);

        // R2: narrow form ignores upper operand halves
        verify("R2", enc(1'b0, 2'b10, 5'd3, 6'd4, 5'd2, 5'd1), 64'hABCD_0000_0000_0010, 64'h1234_5678_8000_0000);
        check("R2", "upper zero", result[63:32], 64'd0);

        // random encodings against the model
        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 8 != 0) begin
                w[30:24] = 7'b0101011;
                w[21]    = 1'b0;
                if (w[23:22] == 2'b11) w[23:22] = 2'(k % 3);
                if (!w[31]) w[15] = 1'b0;
            end
            if (k % 16 == 3) w[9:5] = 5'd31;
            if (k % 16 == 5) w[20:16] = 5'd31;
            if (k % 16 == 7) w[4:0] = 5'd31;
            verify(w[31] ? "R3" : "R2", w, {$urandom, $urandom}, {$urandom, $urandom});
        end

        // R12: reset in mid-stream clears valid
        @(negedge clk);
        instr = enc(1'b1, 2'b00, 5'd3, 6'd0, 5'd2, 5'd1);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R12", "reset beats strobe", {61'd0, out_valid, wr_en, flags_en}, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule